// File: doc/BRIEF.md
# Staged Configuration Commit Bank

This block is a byte-wide configuration register bank that sits behind a serial control port. Any byte written to an ordinary address takes effect on the clock edge that accepts the write. Two address spans are handled differently. Writes to these spans land in a shadow copy first. The active copy changes only when the span's commit control is triggered, and it then takes all bytes of the span on the same edge.

The wide span has eight bytes. Its commit control is a bit that clears itself. The narrow span has two bytes. Its commit control is a bit that stays set, and only its 0-to-1 change moves the shadow bytes across. Software may write any number of shadow bytes before it commits. A readback port shows the shadow value for a staged address, and the single active value for every other address. The consumer sees all active bytes on one flat vector.

Top module: `cfg_commit_bank`

## Requirements
- R1: A write to an address outside both staged spans and outside both commit controls changes that byte of `active_cfg` on the clock edge that accepts the write. This includes the bytes next to the spans (0x15, 0x1F, 0x25).
- R2: A write to 0x16..0x1D changes only the shadow byte. The active bytes 0x16..0x1D keep their value until a commit of that span.
- R3: A write to 0x1E with data bit 7 = 1 copies all eight shadow bytes 0x16..0x1D into the active bytes on that edge. A write to 0x1E with bit 7 = 0 copies nothing.
- R4: Bit 7 of 0x1E is never held at 1. From the cycle after the write it reads 0 on both the readback port and `active_cfg`. Bits 6..0 of 0x1E are stored as written.
- R5: A write to 0x22 or 0x23 changes only the shadow byte. The active bytes 0x22..0x23 keep their value until a commit of that span.
- R6: A write to 0x24 whose data bit 7 is 1, while stored bit 7 of 0x24 is 0, copies both shadow bytes 0x22..0x23 into the active bytes on that edge.
- R7: 0x24 stores all eight bits as written, so bit 7 stays set. A write with bit 7 = 1 while stored bit 7 is already 1 copies nothing. Clearing bit 7 and then setting it again gives a new copy.
- R8: `rd_data` is combinational from `rd_addr`. It shows the shadow byte for 0x16..0x1D and 0x22..0x23, and the active byte for every other address.
- R9: After reset, the shadow byte and the active byte at every address hold `addr ^ 8'h25`, with bit 7 forced to 0 for 0x1E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One-cycle byte write strobe |
| wr_addr | input | ADDR_W (6) | Byte address of the write |
| wr_data | input | 8 | Byte written |
| rd_addr | input | ADDR_W (6) | Readback address |
| rd_data | output | 8 | Readback byte (shadow view for staged spans) |
| active_cfg | output | NREGS*8 (512) | All active bytes, byte n at bits n*8+7..n*8 |

## Verification
The bench builds the block with its default parameters: a 64-byte space, the eight-byte self-clearing span at 0x16 and the two-byte edge-triggered span at 0x22. With these values every span boundary can be reached, and so can each neighbouring ordinary address and both commit controls. The directed sequences write part of a span, commit it, and then confirm that bytes never written come across unchanged. They also re-arm the sticky control without a fresh 0-to-1 change, to show that the edge detection holds.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

  localparam int BYTE_W = 8;

  // Power-up content of every byte, shared by shadow and active copies.
  function automatic logic [BYTE_W-1:0] reset_value(int unsigned addr);
    return BYTE_W'(addr) ^ 8'h25;
  endfunction

  // True when addr lies in [base, base+count).
  function automatic bit in_span(int unsigned addr, int unsigned base,
                                 int unsigned count);
    return (addr >= base) && (addr < base + count);
  endfunction

  // Byte actually stored by a commit control after a write.
  function automatic logic [BYTE_W-1:0] ctrl_store(logic [BYTE_W-1:0] data,
                                                    int unsigned bitpos,
                                                    bit self_clear);
    logic [BYTE_W-1:0] mask;
    mask = BYTE_W'(1) << bitpos;
    return self_clear ? (data & ~mask) : data;
  endfunction

endpackage

// File: rtl/cfg_stage_group.sv
module cfg_stage_group
  import cfg_bank_pkg::*;
#(
  parameter int BASE   = 22,
  parameter int COUNT  = 8,
  parameter int ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [BYTE_W-1:0]         wr_data,
  input  logic                      commit,
  output logic [COUNT*BYTE_W-1:0]   stage_q,
  output logic [COUNT*BYTE_W-1:0]   active_q
);

  for (genvar i = 0; i < COUNT; i++) begin : g_byte
    localparam int ADDR = BASE + i;
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(ADDR));

    // Shadow byte: loaded by writes only.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stage_q[i*BYTE_W +: BYTE_W] <= reset_value(ADDR);
      else if (hit) stage_q[i*BYTE_W +: BYTE_W] <= wr_data;
    end

    // Active byte: loaded from shadow only on commit, all bytes together.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      active_q[i*BYTE_W +: BYTE_W] <= reset_value(ADDR);
      else if (commit) active_q[i*BYTE_W +: BYTE_W] <= stage_q[i*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/cfg_commit_ctrl.sv
module cfg_commit_ctrl
  import cfg_bank_pkg::*;
#(
  parameter int ADDR       = 30,
  parameter int ADDR_W     = 6,
  parameter int BITPOS     = 7,
  parameter bit SELF_CLEAR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              commit
);

  logic hit;
  assign hit = wr_en && (wr_addr == ADDR_W'(ADDR));

  if (SELF_CLEAR) begin : g_pulse
    // Any write with the bit set fires; the bit is never kept.
    assign commit = hit && wr_data[BITPOS];
  end else begin : g_edge
    // Fires only on a 0 -> 1 change of the stored bit.
    assign commit = hit && wr_data[BITPOS] && !ctrl_q[BITPOS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ctrl_q <= ctrl_store(reset_value(ADDR), BITPOS, 1'b1);
    else if (hit) ctrl_q <= ctrl_store(wr_data, BITPOS, SELF_CLEAR);
  end

endmodule

// File: rtl/cfg_plain_regs.sv
module cfg_plain_regs
  import cfg_bank_pkg::*;
#(
  parameter int NREGS   = 64,
  parameter int ADDR_W  = 6,
  parameter int A_BASE  = 22,
  parameter int A_COUNT = 8,
  parameter int A_CTRL  = 30,
  parameter int B_BASE  = 34,
  parameter int B_COUNT = 2,
  parameter int B_CTRL  = 36
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  output logic [NREGS*BYTE_W-1:0] plain_q
);

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    localparam bit PLAIN = !in_span(i, A_BASE, A_COUNT) && !in_span(i, B_BASE, B_COUNT)
                           && (i != A_CTRL) && (i != B_CTRL);
    if (PLAIN) begin : g_ff
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          plain_q[i*BYTE_W +: BYTE_W] <= reset_value(i);
        else if (wr_en && wr_addr == ADDR_W'(i))
          plain_q[i*BYTE_W +: BYTE_W] <= wr_data;
      end
    end else begin : g_zero
      // Zero so the top can merge overlays with a plain OR.
      assign plain_q[i*BYTE_W +: BYTE_W] = '0;
    end
  end

endmodule

// File: rtl/cfg_commit_bank.sv
module cfg_commit_bank
  import cfg_bank_pkg::*;
#(
  parameter int NREGS   = 64,
  parameter int A_BASE  = 22,
  parameter int A_COUNT = 8,
  parameter int A_CTRL  = 30,
  parameter int B_BASE  = 34,
  parameter int B_COUNT = 2,
  parameter int B_CTRL  = 36,
  parameter int BITPOS  = 7,
  localparam int ADDR_W = $clog2(NREGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data,
  output logic [NREGS*8-1:0]      active_cfg
);

  localparam int TOT_W = NREGS * BYTE_W;

  // Named internal events, observed by the bound checker.
  logic                        commit_a, commit_b;
  logic [BYTE_W-1:0]           ctrl_a_q, ctrl_b_q;
  logic [A_COUNT*BYTE_W-1:0]   stage_a, act_a;
  logic [B_COUNT*BYTE_W-1:0]   stage_b, act_b;
  logic [TOT_W-1:0]            plain_q, overlay, view;

  cfg_plain_regs #(
    .NREGS(NREGS), .ADDR_W(ADDR_W),
    .A_BASE(A_BASE), .A_COUNT(A_COUNT), .A_CTRL(A_CTRL),
    .B_BASE(B_BASE), .B_COUNT(B_COUNT), .B_CTRL(B_CTRL)
  ) u_plain (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .plain_q(plain_q)
  );

  cfg_commit_ctrl #(.ADDR(A_CTRL), .ADDR_W(ADDR_W), .BITPOS(BITPOS), .SELF_CLEAR(1'b1))
  u_ctrl_a (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_q(ctrl_a_q), .commit(commit_a)
  );

  cfg_commit_ctrl #(.ADDR(B_CTRL), .ADDR_W(ADDR_W), .BITPOS(BITPOS), .SELF_CLEAR(1'b0))
  u_ctrl_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_q(ctrl_b_q), .commit(commit_b)
  );

  cfg_stage_group #(.BASE(A_BASE), .COUNT(A_COUNT), .ADDR_W(ADDR_W)) u_grp_a (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit_a), .stage_q(stage_a), .active_q(act_a)
  );

  cfg_stage_group #(.BASE(B_BASE), .COUNT(B_COUNT), .ADDR_W(ADDR_W)) u_grp_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit_b), .stage_q(stage_b), .active_q(act_b)
  );

  // Build the overlay (non-plain bytes) and the readback view per address.
  for (genvar i = 0; i < NREGS; i++) begin : g_map
    if (in_span(i, A_BASE, A_COUNT)) begin : g_a
      assign overlay[i*BYTE_W +: BYTE_W] = act_a[(i-A_BASE)*BYTE_W +: BYTE_W];
      assign view[i*BYTE_W +: BYTE_W]    = stage_a[(i-A_BASE)*BYTE_W +: BYTE_W];
    end else if (in_span(i, B_BASE, B_COUNT)) begin : g_b
      assign overlay[i*BYTE_W +: BYTE_W] = act_b[(i-B_BASE)*BYTE_W +: BYTE_W];
      assign view[i*BYTE_W +: BYTE_W]    = stage_b[(i-B_BASE)*BYTE_W +: BYTE_W];
    end else if (i == A_CTRL) begin : g_ca
      assign overlay[i*BYTE_W +: BYTE_W] = ctrl_a_q;
      assign view[i*BYTE_W +: BYTE_W]    = active_cfg[i*BYTE_W +: BYTE_W];
    end else if (i == B_CTRL) begin : g_cb
      assign overlay[i*BYTE_W +: BYTE_W] = ctrl_b_q;
      assign view[i*BYTE_W +: BYTE_W]    = active_cfg[i*BYTE_W +: BYTE_W];
    end else begin : g_p
      assign overlay[i*BYTE_W +: BYTE_W] = '0;
      assign view[i*BYTE_W +: BYTE_W]    = active_cfg[i*BYTE_W +: BYTE_W];
    end
  end

  // Each source is zero outside its own addresses, so OR merges them.
  assign active_cfg = plain_q | overlay;
  assign rd_data    = view[rd_addr*BYTE_W +: BYTE_W];

endmodule

// File: rtl/cfg_commit_bank_chk.sv
module cfg_commit_bank_chk
  import cfg_bank_pkg::*;
#(
  parameter int NREGS   = 64,
  parameter int A_BASE  = 22,
  parameter int A_COUNT = 8,
  parameter int A_CTRL  = 30,
  parameter int B_BASE  = 34,
  parameter int B_COUNT = 2,
  parameter int B_CTRL  = 36,
  parameter int BITPOS  = 7,
  parameter int ADDR_W  = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [7:0]                 wr_data,
  input logic [NREGS*8-1:0]         active_cfg,
  input logic                       commit_a,
  input logic                       commit_b,
  input logic [A_COUNT*8-1:0]       stage_a,
  input logic [B_COUNT*8-1:0]       stage_b
);

  localparam int A_LO = A_BASE * 8;
  localparam int A_W  = A_COUNT * 8;
  localparam int B_LO = B_BASE * 8;
  localparam int B_W  = B_COUNT * 8;

  logic              wr_plain;
  logic [ADDR_W-1:0] last_addr;
  logic [7:0]        last_byte;

  assign wr_plain = wr_en && !in_span(int'(wr_addr), A_BASE, A_COUNT)
                    && !in_span(int'(wr_addr), B_BASE, B_COUNT)
                    && int'(wr_addr) != A_CTRL && int'(wr_addr) != B_CTRL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_addr <= '0;
    else        last_addr <= wr_addr;
  end
  assign last_byte = active_cfg[last_addr*8 +: 8];

  // R1
  p_plain_now_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_plain |=> last_byte == $past(wr_data));
  // R2
  p_a_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_a |=> $stable(active_cfg[A_LO +: A_W]));
  // R3
  p_a_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_a |=> active_cfg[A_LO +: A_W] == $past(stage_a));
  // R4
  p_a_selfclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_a |=> !active_cfg[A_CTRL*8 + BITPOS]);
  // R5
  p_b_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_b |=> $stable(active_cfg[B_LO +: B_W]));
  // R6
  p_b_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_b |=> active_cfg[B_LO +: B_W] == $past(stage_b));
  // R7
  p_b_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_b |-> !active_cfg[B_CTRL*8 + BITPOS]);
  // R7: sticky bit held once set
  p_b_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_b |=> active_cfg[B_CTRL*8 + BITPOS]);

endmodule

bind cfg_commit_bank cfg_commit_bank_chk #(
  .NREGS(NREGS), .A_BASE(A_BASE), .A_COUNT(A_COUNT), .A_CTRL(A_CTRL),
  .B_BASE(B_BASE), .B_COUNT(B_COUNT), .B_CTRL(B_CTRL), .BITPOS(BITPOS),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .active_cfg(active_cfg), .commit_a(commit_a),
  .commit_b(commit_b), .stage_a(stage_a), .stage_b(stage_b)
);

// File: tb/cfg_commit_bank_test.sv
module cfg_commit_bank_test;

  localparam int NREGS = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [5:0]       wr_addr = '0;
  logic [7:0]       wr_data = '0;
  logic [5:0]       rd_addr = '0;
  logic [7:0]       rd_data;
  logic [NREGS*8-1:0] active_cfg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cfg_commit_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .active_cfg(active_cfg)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] dflt(int a);
    return 8'(a) ^ 8'h25;
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic chk_act(string req, int a, logic [7:0] exp);
    check(req, active_cfg[a*8 +: 8], exp);
  endtask

  task automatic chk_rd(string req, int a, logic [7:0] exp);
    rd_addr = 6'(a);
    #1;
    check(req, rd_data, exp);
  endtask

  // Drive on negedge; return one negedge later, after the accepting edge.
  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;  // R9
    for (int a = 0; a < NREGS; a++) chk_act("R9 active default", a, dflt(a));
    chk_rd("R9 shadow default 0x16", 'h16, dflt('h16));
    chk_rd("R9 shadow default 0x23", 'h23, dflt('h23));
  endtask

  task automatic t_plain;  // R1
    wr('h05, 8'hA7); chk_act("R1 plain 0x05", 'h05, 8'hA7);
    wr('h15, 8'h3C); chk_act("R1 edge 0x15", 'h15, 8'h3C);
    wr('h1F, 8'h11); chk_act("R1 edge 0x1F", 'h1F, 8'h11);
    wr('h25, 8'h99); chk_act("R1 edge 0x25", 'h25, 8'h99);
    chk_rd("R8 plain readback 0x1F", 'h1F, 8'h11);
  endtask

  task automatic t_stage_a;  // R2, R8
    wr('h16, 8'h10);
    wr('h1D, 8'h81);
    chk_act("R2 0x16 held", 'h16, dflt('h16));
    chk_act("R2 0x1D held", 'h1D, dflt('h1D));
    chk_rd("R8 shadow 0x16", 'h16, 8'h10);
    chk_rd("R8 shadow 0x1D", 'h1D, 8'h81);
  endtask

  task automatic t_commit_a;  // R3, R4
    wr('h1E, 8'h85);
    chk_act("R3 commit 0x16", 'h16, 8'h10);
    chk_act("R3 commit 0x1D", 'h1D, 8'h81);
    chk_act("R3 unwritten 0x19", 'h19, dflt('h19));
    chk_act("R4 bit7 clear active", 'h1E, 8'h05);
    chk_rd("R4 bit7 clear readback", 'h1E, 8'h05);
    wr('h17, 8'h44);
    wr('h1E, 8'h05);
    chk_act("R3 no commit bit7=0", 'h17, dflt('h17));
    wr('h1E, 8'h80);
    chk_act("R3 second commit", 'h17, 8'h44);
    chk_act("R3 earlier kept", 'h16, 8'h10);
  endtask

  task automatic t_stage_b;  // R5
    wr('h22, 8'hC3);
    wr('h23, 8'h5A);
    chk_act("R5 0x22 held", 'h22, dflt('h22));
    chk_act("R5 0x23 held", 'h23, dflt('h23));
    chk_rd("R8 shadow 0x23", 'h23, 8'h5A);
  endtask

  task automatic t_commit_b;  // R6
    wr('h24, 8'h80);
    chk_act("R6 commit 0x22", 'h22, 8'hC3);
    chk_act("R6 commit 0x23", 'h23, 8'h5A);
    chk_rd("R7 bit7 sticky", 'h24, 8'h80);
  endtask

  task automatic t_sticky;  // R7
    wr('h22, 8'h12);
    wr('h24, 8'h81);
    chk_act("R7 rewrite 1 no commit", 'h22, 8'hC3);
    chk_rd("R7 stored as written", 'h24, 8'h81);
    wr('h24, 8'h00);
    chk_act("R7 clear no commit", 'h22, 8'hC3);
    wr('h24, 8'h80);
    chk_act("R7 re-armed commit", 'h22, 8'h12);
    chk_act("R7 other byte kept", 'h23, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_stage_a();
    t_commit_a();
    t_stage_b();
    t_commit_b();
    t_sticky();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule